// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Dispatcher

This block is the state-update stage of a small processor's trap unit. Each clock cycle it looks at the current program counter and status word, the pending interrupt level, the pending and enable masks, and an optional synchronous exception request. It then decides whether control is redirected. If it is, it produces the next program counter and the new status word on the next clock edge. On that same edge it writes the saved return addresses, the saved status copies, the double-trap return register and the cause register, and it raises a one-cycle taken strobe.

A synchronous exception has priority over any interrupt in the same cycle. It only redirects the program counter. An interrupt at level 2 or above vectors directly to its level's entry and saves state in that level's own slots. A level-1 interrupt becomes a kernel, user or double trap, chosen from the status bits.

All pins are plain control and status pins. They are sampled on every rising edge, and no valid/ready handshake applies, because the block consumes one decision per cycle and can never stall.

Top module: `irq_dispatch_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0x5FFF8000 and `taken_o` is 0. All saved-address, saved-status, double-return and cause outputs are 0. `ps_o` is 0x1F when `HAS_INT_OPTION` is 1 and 0x10 when it is 0.
- R2: The status word layout is: current interrupt level in bits [3:0], trap-mode flag in bit 4, user-mode flag in bit 5. An interrupt is accepted only if all three conditions hold:
  - `pend_level_i` is greater than the current interrupt level;
  - `pend_level_i` is at most `NUM_LEVELS`;
  - the level's interrupt mask ANDed with `int_set_i` and `int_en_i` is nonzero. Interrupt i belongs to the level held in `INT_LEVELS[4i+3:4i]`.
  
  When nothing is taken, `pc_o`/`ps_o` copy `pc_i`/`ps_i` one cycle later, `taken_o` stays 0, and no saved register changes.
- R3: An accepted interrupt at level L ≥ 2 has these effects:
  - saved address slot L (`epc_o[32(L-1)+:32]`) receives `pc_i`;
  - saved status slot L (`eps_o[8(L-2)+:8]`) receives `ps_i`;
  - `ps_o` is `ps_i` with bits [3:0] = L and bit 4 set;
  - `pc_o` becomes 0x5FFF857C + 0x20·(L−2).
- R4: An accepted level-1 interrupt with bits 4 and 5 of `ps_i` clear saves `pc_i` in slot 1. It sets `ps_o` to `ps_i` with bit 4 set, loads cause code 4 into `cause_o`, and sets `pc_o` to 0x5FFF861C.
- R5: Level-1 case with bit 4 clear and bit 5 set: same effects as R4, except `pc_o` becomes 0x5FFF863C.
- R6: Level-1 case with bit 4 set: cause code 4 is loaded and `pc_o` becomes 0x5FFF865C. `pc_i` is saved in `depc_o` when `HAS_DEPC` is 1, and in saved address slot 1 when `HAS_DEPC` is 0.
- R7: A synchronous exception with `exc_idx_i` 0 to 5 (window spill/fill for 4, 8 and 12 registers) sets `pc_o` to 0x5FFF8400 + 0x40·index. Index 6 goes to the kernel entry, 7 to the user entry and 8 to the double entry. `ps_o` copies `ps_i` and no saved register changes.
- R8: A synchronous exception with index 9 to 15 has no vector. `pc_o` copies `pc_i`, `taken_o` stays 0 and nothing else changes.
- R9: While `exc_req_i` is high, no interrupt is accepted in that cycle, even one that meets every R2 condition.
- R10: Every redirect raises `taken_o` for exactly the cycle in which the new `pc_o` appears, and all register updates of that redirect are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_level_i | input | 4 | Highest pending interrupt level |
| int_set_i | input | NUM_INTS | Pending interrupt bits |
| int_en_i | input | NUM_INTS | Interrupt enable bits |
| ps_i | input | PSW | Current status word |
| pc_i | input | 32 | Current program counter |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_idx_i | input | 4 | Synchronous exception index |
| pc_o | output | 32 | Next program counter |
| ps_o | output | PSW | Updated status word |
| epc_o | output | NUM_LEVELS·32 | Saved return addresses, slot L at bits 32(L-1) upward |
| eps_o | output | (NUM_LEVELS-1)·PSW | Saved status copies, slot L at bits PSW(L-2) upward |
| depc_o | output | 32 | Double-trap return address |
| cause_o | output | CAUSE_W | Cause register |
| taken_o | output | 1 | One-cycle redirect strobe |

## Verification
The bench builds two copies with the default interrupt-to-level map of 13 lines over 6 levels. The first copy has a separate double-trap register and the interrupt option enabled. The second has no double-trap register and the interrupt option disabled. With both copies, the 0x1F and 0x10 reset status words can be checked, and so can both places where a nested level-1 return address may land. Because the default map gives every level at least one line, the bench can reach each level's vector, its save slots, and the strict-greater comparison at the level boundary.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned EXC_IDX_W = 4;
  localparam int unsigned PS_EXCM   = 4;
  localparam int unsigned PS_UM     = 5;
  localparam int unsigned L1_CAUSE  = 4;

  localparam logic [ADDR_W-1:0] VEC_RESET   = 32'h5FFF_8000;
  localparam logic [ADDR_W-1:0] VEC_WIN     = 32'h5FFF_8400;
  localparam logic [ADDR_W-1:0] VEC_WSTEP   = 32'h0000_0040;
  localparam logic [ADDR_W-1:0] VEC_LVL2    = 32'h5FFF_857C;
  localparam logic [ADDR_W-1:0] VEC_LSTEP   = 32'h0000_0020;
  localparam logic [ADDR_W-1:0] VEC_KERNEL  = 32'h5FFF_861C;
  localparam logic [ADDR_W-1:0] VEC_USER    = 32'h5FFF_863C;
  localparam logic [ADDR_W-1:0] VEC_DOUBLE  = 32'h5FFF_865C;

  localparam int unsigned NUM_WIN_EXC = 6;
  localparam int unsigned IDX_KERNEL  = 6;
  localparam int unsigned IDX_USER    = 7;
  localparam int unsigned IDX_DOUBLE  = 8;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SYNC,
    ACT_HIGH,
    ACT_KERN,
    ACT_USER,
    ACT_DBL
  } act_e;

  function automatic logic [ADDR_W-1:0] lvl_vec(input logic [3:0] lvl);
    return VEC_LVL2 + (ADDR_W'(lvl) - ADDR_W'(2)) * VEC_LSTEP;
  endfunction

  function automatic logic [ADDR_W-1:0] exc_vec(input logic [EXC_IDX_W-1:0] idx);
    logic [ADDR_W-1:0] v;
    if (32'(idx) < NUM_WIN_EXC)       v = VEC_WIN + ADDR_W'(idx) * VEC_WSTEP;
    else if (32'(idx) == IDX_KERNEL)  v = VEC_KERNEL;
    else if (32'(idx) == IDX_USER)    v = VEC_USER;
    else if (32'(idx) == IDX_DOUBLE)  v = VEC_DOUBLE;
    else                              v = '0;
    return v;
  endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_disp_pkg::*;
#(
  parameter int NUM_INTS   = 13,
  parameter int NUM_LEVELS = 6,
  parameter int LVL_W      = 4,
  parameter logic [NUM_INTS*LVL_W-1:0] INT_LEVELS = '0
) (
  input  logic [LVL_W-1:0]    pend_level_i,
  input  logic [LVL_W-1:0]    cur_level_i,
  input  logic [NUM_INTS-1:0] int_set_i,
  input  logic [NUM_INTS-1:0] int_en_i,
  output logic                accept_o
);

  logic [NUM_INTS-1:0] lvl_mask [NUM_LEVELS+1];
  logic [NUM_INTS-1:0] sel_mask;
  logic                above, in_range;

  for (genvar l = 0; l <= NUM_LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_INTS; i++) begin : g_int
      assign lvl_mask[l][i] = (l != 0) &&
                              (INT_LEVELS[i*LVL_W +: LVL_W] == LVL_W'(l));
    end
  end

  always_comb begin
    sel_mask = '0;
    for (int l = 0; l <= NUM_LEVELS; l++) begin
      if (pend_level_i == LVL_W'(l)) sel_mask = lvl_mask[l];
    end
  end

  assign above    = pend_level_i > cur_level_i;
  assign in_range = pend_level_i <= LVL_W'(NUM_LEVELS);
  assign accept_o = above && in_range && |(sel_mask & int_set_i & int_en_i);

endmodule

// File: rtl/irq_action_sel.sv
module irq_action_sel
  import irq_disp_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic                 exc_req_i,
  input  logic [EXC_IDX_W-1:0] exc_idx_i,
  input  logic                 accept_i,
  input  logic [LVL_W-1:0]     level_i,
  input  logic                 excm_i,
  input  logic                 um_i,
  output act_e                 act_o,
  output logic [ADDR_W-1:0]    target_o
);

  logic [ADDR_W-1:0] sync_vec;

  assign sync_vec = exc_vec(exc_idx_i);

  always_comb begin
    act_o    = ACT_NONE;
    target_o = '0;
    if (exc_req_i) begin
      if (sync_vec != '0) begin
        act_o    = ACT_SYNC;
        target_o = sync_vec;
      end
    end else if (accept_i) begin
      if (level_i == LVL_W'(1)) begin
        if (excm_i) begin
          act_o    = ACT_DBL;
          target_o = VEC_DOUBLE;
        end else if (um_i) begin
          act_o    = ACT_USER;
          target_o = VEC_USER;
        end else begin
          act_o    = ACT_KERN;
          target_o = VEC_KERNEL;
        end
      end else begin
        act_o    = ACT_HIGH;
        target_o = lvl_vec(4'(level_i));
      end
    end
  end

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
  import irq_disp_pkg::*;
#(
  parameter int NUM_LEVELS = 6,
  parameter int LVL_W      = 4,
  parameter int PSW        = 8,
  parameter int CAUSE_W    = 6,
  parameter bit HAS_DEPC   = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  act_e                            act_i,
  input  logic [LVL_W-1:0]                level_i,
  input  logic [ADDR_W-1:0]               pc_i,
  input  logic [PSW-1:0]                  ps_i,
  output logic [NUM_LEVELS*ADDR_W-1:0]    epc_o,
  output logic [(NUM_LEVELS-1)*PSW-1:0]   eps_o,
  output logic [ADDR_W-1:0]               depc_o,
  output logic [CAUSE_W-1:0]              cause_o
);

  logic l1_trap, dbl_to_slot1;

  assign l1_trap      = (act_i == ACT_KERN) || (act_i == ACT_USER) || (act_i == ACT_DBL);
  assign dbl_to_slot1 = (act_i == ACT_DBL) && !HAS_DEPC;

  for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_slot
    logic epc_we;
    logic [ADDR_W-1:0] epc_q;

    if (l == 1) begin : g_l1
      assign epc_we = (act_i == ACT_KERN) || (act_i == ACT_USER) || dbl_to_slot1;
    end else begin : g_hi
      assign epc_we = (act_i == ACT_HIGH) && (level_i == LVL_W'(l));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      epc_q <= '0;
      else if (epc_we) epc_q <= pc_i;
    end
    assign epc_o[(l-1)*ADDR_W +: ADDR_W] = epc_q;

    if (l >= 2) begin : g_eps
      logic [PSW-1:0] eps_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      eps_q <= '0;
        else if (epc_we) eps_q <= ps_i;
      end
      assign eps_o[(l-2)*PSW +: PSW] = eps_q;

      assert_eps_other_lvl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i != ACT_HIGH) |=> $stable(eps_o[(l-2)*PSW +: PSW]));
    end
  end

  if (HAS_DEPC) begin : g_depc
    logic [ADDR_W-1:0] depc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                depc_q <= '0;
      else if (act_i == ACT_DBL) depc_q <= pc_i;
    end
    assign depc_o = depc_q;
  end else begin : g_no_depc
    assign depc_o = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cause_o <= '0;
    else if (l1_trap) cause_o <= CAUSE_W'(L1_CAUSE);
  end

  assert_sync_keeps_slot1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_SYNC) |=> $stable(epc_o[ADDR_W-1:0]) && $stable(depc_o) && $stable(cause_o));

endmodule

// File: rtl/irq_dispatch_core.sv
module irq_dispatch_core
  import irq_disp_pkg::*;
#(
  parameter int NUM_INTS       = 13,
  parameter int NUM_LEVELS     = 6,
  parameter int PSW            = 8,
  parameter int CAUSE_W        = 6,
  parameter bit HAS_DEPC       = 1'b1,
  parameter bit HAS_INT_OPTION = 1'b1,
  parameter logic [NUM_INTS*4-1:0] INT_LEVELS = 52'h1654326532114
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [3:0]                        pend_level_i,
  input  logic [NUM_INTS-1:0]               int_set_i,
  input  logic [NUM_INTS-1:0]               int_en_i,
  input  logic [PSW-1:0]                    ps_i,
  input  logic [31:0]                       pc_i,
  input  logic                              exc_req_i,
  input  logic [3:0]                        exc_idx_i,
  output logic [31:0]                       pc_o,
  output logic [PSW-1:0]                    ps_o,
  output logic [NUM_LEVELS*32-1:0]          epc_o,
  output logic [(NUM_LEVELS-1)*PSW-1:0]     eps_o,
  output logic [31:0]                       depc_o,
  output logic [CAUSE_W-1:0]                cause_o,
  output logic                              taken_o
);

  localparam int LVL_W = 4;
  localparam logic [PSW-1:0] RESET_PS = HAS_INT_OPTION ? PSW'(8'h1F) : PSW'(8'h10);

  logic              accept;
  act_e              act;
  logic [ADDR_W-1:0] target;
  logic [PSW-1:0]    ps_next;

  irq_level_gate #(
    .NUM_INTS  (NUM_INTS),
    .NUM_LEVELS(NUM_LEVELS),
    .LVL_W     (LVL_W),
    .INT_LEVELS(INT_LEVELS)
  ) u_gate (
    .pend_level_i(pend_level_i),
    .cur_level_i (ps_i[LVL_W-1:0]),
    .int_set_i   (int_set_i),
    .int_en_i    (int_en_i),
    .accept_o    (accept)
  );

  irq_action_sel #(.LVL_W(LVL_W)) u_sel (
    .exc_req_i(exc_req_i),
    .exc_idx_i(exc_idx_i),
    .accept_i (accept),
    .level_i  (pend_level_i),
    .excm_i   (ps_i[PS_EXCM]),
    .um_i     (ps_i[PS_UM]),
    .act_o    (act),
    .target_o (target)
  );

  irq_save_bank #(
    .NUM_LEVELS(NUM_LEVELS),
    .LVL_W     (LVL_W),
    .PSW       (PSW),
    .CAUSE_W   (CAUSE_W),
    .HAS_DEPC  (HAS_DEPC)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (act),
    .level_i(pend_level_i),
    .pc_i   (pc_i),
    .ps_i   (ps_i),
    .epc_o  (epc_o),
    .eps_o  (eps_o),
    .depc_o (depc_o),
    .cause_o(cause_o)
  );

  always_comb begin
    ps_next = ps_i;
    case (act)
      ACT_HIGH: begin
        ps_next[LVL_W-1:0] = pend_level_i;
        ps_next[PS_EXCM]   = 1'b1;
      end
      ACT_KERN, ACT_USER, ACT_DBL: ps_next[PS_EXCM] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o    <= VEC_RESET;
      ps_o    <= RESET_PS;
      taken_o <= 1'b0;
    end else begin
      pc_o    <= (act != ACT_NONE) ? target : pc_i;
      ps_o    <= ps_next;
      taken_o <= (act != ACT_NONE);
    end
  end

  assert_accept_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && accept) |=> taken_o);

  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_i && !accept) |=> (!taken_o && pc_o == $past(pc_i) && ps_o == $past(ps_i)));

  assert_high_ps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HIGH) |=> (ps_o[PS_EXCM] && ps_o[LVL_W-1:0] == $past(pend_level_i)));

  assert_l1_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_KERN || act == ACT_USER) |=> (cause_o == CAUSE_W'(L1_CAUSE) && ps_o[PS_EXCM]));

  assert_user_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_USER) |=> (pc_o == VEC_USER));

  assert_dbl_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DBL) |=> (pc_o == VEC_DOUBLE && cause_o == CAUSE_W'(L1_CAUSE)));

  assert_sync_ps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SYNC) |=> (taken_o && ps_o == $past(ps_i)));

  assert_no_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && exc_vec(exc_idx_i) == '0) |=> (!taken_o && pc_o == $past(pc_i)));

  assert_sync_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_i && exc_vec(exc_idx_i) != '0) |=> (taken_o && pc_o == $past(exc_vec(exc_idx_i))));

endmodule

// File: tb/irq_dispatch_core_tb_top.sv
module irq_dispatch_core_tb_top;

  localparam int NI = 13;
  localparam int NL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]    pend_level;
  logic [NI-1:0] int_set, int_en;
  logic [7:0]    ps_in;
  logic [31:0]   pc_in;
  logic          exc_req;
  logic [3:0]    exc_idx;

  logic [31:0]      a_pc, b_pc, a_depc, b_depc;
  logic [7:0]       a_ps, b_ps;
  logic [NL*32-1:0] a_epc, b_epc;
  logic [(NL-1)*8-1:0] a_eps, b_eps;
  logic [5:0]       a_cause, b_cause;
  logic             a_tk, b_tk;

  irq_dispatch_core dut_i (
    .clk(clk), .rst_n(rst_n), .pend_level_i(pend_level), .int_set_i(int_set),
    .int_en_i(int_en), .ps_i(ps_in), .pc_i(pc_in), .exc_req_i(exc_req),
    .exc_idx_i(exc_idx), .pc_o(a_pc), .ps_o(a_ps), .epc_o(a_epc), .eps_o(a_eps),
    .depc_o(a_depc), .cause_o(a_cause), .taken_o(a_tk));

  irq_dispatch_core #(.HAS_DEPC(1'b0), .HAS_INT_OPTION(1'b0)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .pend_level_i(pend_level), .int_set_i(int_set),
    .int_en_i(int_en), .ps_i(ps_in), .pc_i(pc_in), .exc_req_i(exc_req),
    .exc_idx_i(exc_idx), .pc_o(b_pc), .ps_o(b_ps), .epc_o(b_epc), .eps_o(b_eps),
    .depc_o(b_depc), .cause_o(b_cause), .taken_o(b_tk));

  typedef struct {
    logic [31:0]         pc;
    logic [7:0]          ps;
    logic                tk;
    logic [NL*32-1:0]    epc;
    logic [(NL-1)*8-1:0] eps;
    logic [31:0]         depc;
    logic [5:0]          cause;
    logic [31:0]         b_epc1;
    string               tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic [NL*32-1:0]    m_epc = '0;
  logic [(NL-1)*8-1:0] m_eps = '0;
  logic [31:0]         m_depc = '0;
  logic [5:0]          m_cause = '0;
  logic [31:0]         m_b_epc1 = '0;

  int lvl_tab [NI] = '{4, 1, 1, 2, 3, 5, 6, 2, 3, 4, 5, 6, 1};

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit hit(input int l, input logic [NI-1:0] s, input logic [NI-1:0] e);
    for (int i = 0; i < NI; i++)
      if (lvl_tab[i] == l && s[i] && e[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] xvec(input int i);
    if (i < 6) return 32'h5FFF8400 + 32'h40 * i;
    if (i == 6) return 32'h5FFF861C;
    if (i == 7) return 32'h5FFF863C;
    if (i == 8) return 32'h5FFF865C;
    return 32'h0;
  endfunction

  task automatic drive(input int pl, input logic [NI-1:0] st, input logic [NI-1:0] en,
                       input logic [7:0] ps, input logic [31:0] pc, input bit er,
                       input int ei, input string tag);
    exp_t e;
    @(negedge clk);
    pend_level = 4'(pl); int_set = st; int_en = en; ps_in = ps; pc_in = pc;
    exc_req = er; exc_idx = 4'(ei);
    e.pc = pc; e.ps = ps; e.tk = 1'b0;
    if (er) begin
      if (xvec(ei) != 0) begin e.pc = xvec(ei); e.tk = 1'b1; end
    end else if (pl > int'(ps[3:0]) && pl <= NL && hit(pl, st, en)) begin
      e.tk = 1'b1;
      if (pl > 1) begin
        m_epc[(pl-1)*32 +: 32] = pc;
        m_eps[(pl-2)*8 +: 8] = ps;
        e.ps = {ps[7:5], 1'b1, 4'(pl)};
        e.pc = 32'h5FFF857C + 32'h20 * (pl - 2);
      end else begin
        m_cause = 6'd4;
        if (ps[4]) begin
          m_depc = pc; m_b_epc1 = pc; e.pc = 32'h5FFF865C;
        end else begin
          m_epc[31:0] = pc; m_b_epc1 = pc;
          e.pc = ps[5] ? 32'h5FFF863C : 32'h5FFF861C;
        end
        e.ps = ps | 8'h10;
      end
    end
    e.epc = m_epc; e.eps = m_eps; e.depc = m_depc; e.cause = m_cause;
    e.b_epc1 = m_b_epc1; e.tag = tag;
    q.push_back(e);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(a_pc == e.pc, e.tag, "pc", 192'(a_pc), 192'(e.pc));
      chk(a_ps == e.ps, e.tag, "ps", 192'(a_ps), 192'(e.ps));
      chk(a_tk == e.tk, e.tag, "taken", 192'(a_tk), 192'(e.tk));
      chk(a_epc == e.epc, e.tag, "epc", 192'(a_epc), 192'(e.epc));
      chk(a_eps == e.eps, e.tag, "eps", 192'(a_eps), 192'(e.eps));
      chk(a_depc == e.depc, e.tag, "depc", 192'(a_depc), 192'(e.depc));
      chk(a_cause == e.cause, e.tag, "cause", 192'(a_cause), 192'(e.cause));
      chk(b_pc == e.pc && b_tk == e.tk, e.tag, "cfgB pc/taken", 192'({b_pc, b_tk}), 192'({e.pc, e.tk}));
      chk(b_epc[31:0] == e.b_epc1, e.tag, "cfgB slot1", 192'(b_epc[31:0]), 192'(e.b_epc1));
      chk(b_depc == 32'h0, e.tag, "cfgB depc", 192'(b_depc), 192'(0));
    end
  end

  bit done = 1'b0;
  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pend_level = '0; int_set = '0; int_en = '0; ps_in = '0; pc_in = '0;
    exc_req = 1'b0; exc_idx = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(a_pc == 32'h5FFF8000, "R1", "pc", 192'(a_pc), 192'(32'h5FFF8000));
    chk(a_ps == 8'h1F, "R1", "ps", 192'(a_ps), 192'(8'h1F));
    chk(b_ps == 8'h10, "R1", "cfgB ps", 192'(b_ps), 192'(8'h10));
    chk(a_tk == 1'b0 && b_tk == 1'b0, "R1", "taken", 192'({a_tk, b_tk}), 192'(0));
    chk(a_epc == '0 && a_eps == '0 && a_depc == '0 && a_cause == '0, "R1", "saved",
        192'(a_epc), 192'(0));
    rst_n = 1'b1;

    drive(0, '0, '0, 8'h00, 32'h1000, 0, 0, "R2 idle");
    drive(3, 13'h0010, 13'h0010, 8'h00, 32'h1004, 0, 0, "R3 level3");
    drive(3, 13'h0010, 13'h0010, 8'h03, 32'h1008, 0, 0, "R2 level not above");
    drive(7, 13'h1FFF, 13'h1FFF, 8'h00, 32'h100C, 0, 0, "R2 level out of range");
    drive(5, 13'h0020, 13'h0000, 8'h00, 32'h1010, 0, 0, "R2 not enabled");
    drive(5, 13'h0040, 13'h0040, 8'h00, 32'h1014, 0, 0, "R2 wrong level line");
    drive(6, 13'h0040, 13'h0040, 8'h25, 32'h1018, 0, 0, "R3 level6 user bit kept");
    drive(2, 13'h0008, 13'h0008, 8'h01, 32'h101C, 0, 0, "R3 level2");
    drive(4, 13'h0200, 13'h0200, 8'h03, 32'h1020, 0, 0, "R3 level4 boundary");
    drive(1, 13'h0002, 13'h0002, 8'h00, 32'h2000, 0, 0, "R4 kernel");
    drive(1, 13'h0004, 13'h0004, 8'h20, 32'h2004, 0, 0, "R5 user");
    drive(1, 13'h1000, 13'h1000, 8'h10, 32'h2008, 0, 0, "R6 double");
    drive(1, 13'h1000, 13'h1000, 8'h31, 32'h200C, 0, 0, "R2 level1 masked");
    for (int i = 0; i < 9; i++)
      drive(0, '0, '0, 8'h07, 32'h3000 + 32'(4 * i), 1, i, "R7 sync vector");
    drive(0, '0, '0, 8'h00, 32'h3100, 1, 9, "R8 no vector idx9");
    drive(0, '0, '0, 8'h00, 32'h3104, 1, 15, "R8 no vector idx15");
    drive(4, 13'h0001, 13'h0001, 8'h00, 32'h3200, 1, 6, "R9 sync beats irq");
    drive(4, 13'h0001, 13'h0001, 8'h00, 32'h3204, 1, 12, "R9 bad sync still blocks irq");
    drive(5, 13'h0020, 13'h0020, 8'h00, 32'h4000, 0, 0, "R10 first");
    drive(2, 13'h0080, 13'h0080, 8'h00, 32'h4004, 0, 0, "R10 second");
    drive(0, '0, '0, 8'h00, 32'h4008, 0, 0, "R10 strobe drops");
    drive(0, '0, '0, 8'h00, 32'h400C, 0, 0, "R10 stays low");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule